// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. When paging is on, it reads two levels of in-memory translation entries. The first is a directory entry, found from a base register and the top ten address bits. The second is a table entry, found from the directory entry's frame and the middle ten address bits. The physical frame from the table entry is then joined with the untouched 12-bit page offset. When paging is off, the address passes straight through and memory is not touched.

Each request states whether it is a read or a write and whether it comes from user or supervisor code. The walker checks that both entries are present and that the access is allowed by the combined protection bits. On success it marks the entries as accessed and, for writes, the table entry as dirty. It issues these write-backs as locked read-modify-write cycles on its memory port. On failure it returns a fault with a 3-bit error code and keeps the faulting linear address in a register. Only one translation is in flight at a time.

Top module: `pw_walker`

## Requirements
- R1: With paging disabled at acceptance, the response carries the physical address equal to the linear address with no fault, and no memory cycle is issued.
- R2: The first memory read goes to {base[31:12], lin[31:22], 2'b00}. The second goes to {dirent[31:12], lin[21:12], 2'b00}.
- R3: On success, the physical address is {tblent[31:12], lin[11:0]}.
- R4: Entry bit 0 is the present flag. An absent directory entry ends the walk after one read, and an absent table entry ends it after two. Either case faults with error code bit 0 = 0, and nothing is written.
- R5: Entry bit 2 is the user-allowed flag and bit 1 is the write-allowed flag. The effective flags are the AND of both entries. A user access faults if the effective user flag is 0, and a user write faults if the effective write flag is 0. Such a fault has error code bit 0 = 1.
- R6: Supervisor accesses never take a protection fault, whatever the user and write flags are.
- R7: Error code bit 1 is 1 for a write and bit 2 is 1 for a user access. On every fault the linear address is latched into fault_addr, which keeps its value until the next fault.
- R8: On success, bit 5 (accessed) is set in both entries. Bit 6 (dirty) is set only in the table entry and only for writes. A faulting access writes no entry.
- R9: An entry is written back only if its value changes. When both change, the directory entry is written first.
- R10: Every memory cycle of a paged walk, reads and write-backs alike, has mem_lock high.
- R11: req_ready is high only when no translation is in flight. A response stays valid and stable until rsp_ready is high. A memory request stays stable until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paging_en | input | 1 | Enable translation, sampled at acceptance |
| dir_base | input | 32 | Directory base register, bits 31:12 used |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_laddr | input | 32 | Linear address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user privilege |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 1 | Translation faulted |
| rsp_ecode | output | 3 | Fault code {user, write, protection} |
| fault_addr | output | 32 | Last faulting linear address |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory cycle is a write |
| mem_lock | output | 1 | Locked cycle |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory cycle completes |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The bench builds the walker with its default 32-bit address, 10-bit index and 12-bit offset. At these values, directory and table index fields, frame joining and the flag bits at positions 0, 1, 2, 5 and 6 are all exercised at the widths the requirements fix. Random entries with a bias toward present entries reach both fault kinds and the four user/write combinations of the ANDed flags. Directed cases cover entries whose accessed or dirty bits are already set, which is where write-backs must be skipped.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int FRM_W  = ADDR_W - OFF_W;

    localparam int BIT_PRES  = 0;
    localparam int BIT_WROK  = 1;
    localparam int BIT_USROK = 2;
    localparam int BIT_ACC   = 5;
    localparam int BIT_DIRTY = 6;

    typedef enum logic [2:0] {
        WS_IDLE, WS_RD_DIR, WS_RD_TBL, WS_WR_DIR, WS_WR_TBL, WS_RESP
    } walk_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] laddr;
        logic              wr;
        logic              user;
    } xreq_t;

    function automatic logic [2:0] make_ecode(input logic prot, input logic wr, input logic user);
        return {user, wr, prot};
    endfunction
endpackage

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-OFF_W-1:0] frame,
    input  logic [IDX_W-1:0]        index,
    output logic [ADDR_W-1:0]       ent_addr
);
    localparam int SLOT_W = OFF_W - IDX_W;
    assign ent_addr = {frame, index, {SLOT_W{1'b0}}};
endmodule

// File: rtl/pw_perm_check.sv
module pw_perm_check
    import pw_pkg::*;
(
    input  logic [ADDR_W-1:0] dent,
    input  logic [ADDR_W-1:0] tent,
    input  logic              wr,
    input  logic              user,
    output logic              viol,
    output logic [ADDR_W-1:0] dent_upd,
    output logic [ADDR_W-1:0] tent_upd,
    output logic              dent_chg,
    output logic              tent_chg
);
    logic eff_usr, eff_wr;

    always_comb begin
        eff_usr  = dent[BIT_USROK] & tent[BIT_USROK];
        eff_wr   = dent[BIT_WROK]  & tent[BIT_WROK];
        viol     = user & (~eff_usr | (wr & ~eff_wr));
        dent_upd = dent;
        dent_upd[BIT_ACC] = 1'b1;
        tent_upd = tent;
        tent_upd[BIT_ACC] = 1'b1;
        if (wr) tent_upd[BIT_DIRTY] = 1'b1;
        dent_chg = (dent_upd != dent);
        tent_chg = (tent_upd != tent);
    end
endmodule

// File: rtl/pw_walker.sv
module pw_walker
    import pw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              paging_en,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_laddr,
    input  logic              req_write,
    input  logic              req_user,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_fault,
    output logic [2:0]        rsp_ecode,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata
);
    walk_state_t       state_q;
    xreq_t             req_q;
    logic [FRM_W-1:0]  base_q;
    logic [ADDR_W-1:0] dent_q, tent_q;
    logic [ADDR_W-1:0] paddr_q, faddr_q;
    logic              fault_q;
    logic [2:0]        ecode_q;

    logic [ADDR_W-1:0] dir_ent_a, tbl_ent_a;
    logic [ADDR_W-1:0] tent_in, dent_upd, tent_upd;
    logic              viol, dent_chg, tent_chg;

    pw_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dir_a (
        .frame    (base_q),
        .index    (req_q.laddr[ADDR_W-1 -: IDX_W]),
        .ent_addr (dir_ent_a)
    );

    pw_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tbl_a (
        .frame    (dent_q[ADDR_W-1:OFF_W]),
        .index    (req_q.laddr[OFF_W +: IDX_W]),
        .ent_addr (tbl_ent_a)
    );

    assign tent_in = (state_q == WS_RD_TBL) ? mem_rdata : tent_q;

    pw_perm_check u_perm (
        .dent     (dent_q),
        .tent     (tent_in),
        .wr       (req_q.wr),
        .user     (req_q.user),
        .viol     (viol),
        .dent_upd (dent_upd),
        .tent_upd (tent_upd),
        .dent_chg (dent_chg),
        .tent_chg (tent_chg)
    );

    always_comb begin
        mem_req   = (state_q == WS_RD_DIR) || (state_q == WS_RD_TBL) ||
                    (state_q == WS_WR_DIR) || (state_q == WS_WR_TBL);
        mem_we    = (state_q == WS_WR_DIR) || (state_q == WS_WR_TBL);
        mem_lock  = mem_req;
        mem_addr  = ((state_q == WS_RD_DIR) || (state_q == WS_WR_DIR)) ? dir_ent_a : tbl_ent_a;
        mem_wdata = (state_q == WS_WR_DIR) ? dent_upd : tent_upd;
    end

    assign req_ready  = (state_q == WS_IDLE);
    assign rsp_valid  = (state_q == WS_RESP);
    assign rsp_paddr  = paddr_q;
    assign rsp_fault  = fault_q;
    assign rsp_ecode  = ecode_q;
    assign fault_addr = faddr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WS_IDLE;
            req_q   <= '0;
            base_q  <= '0;
            dent_q  <= '0;
            tent_q  <= '0;
            paddr_q <= '0;
            faddr_q <= '0;
            fault_q <= 1'b0;
            ecode_q <= '0;
        end else begin
            unique case (state_q)
                WS_IDLE: begin
                    if (req_valid) begin
                        req_q   <= '{laddr: req_laddr, wr: req_write, user: req_user};
                        base_q  <= dir_base[ADDR_W-1:OFF_W];
                        fault_q <= 1'b0;
                        ecode_q <= '0;
                        paddr_q <= req_laddr;
                        state_q <= paging_en ? WS_RD_DIR : WS_RESP;
                    end
                end
                WS_RD_DIR: begin
                    if (mem_ack) begin
                        dent_q <= mem_rdata;
                        if (!mem_rdata[BIT_PRES]) begin
                            fault_q <= 1'b1;
                            ecode_q <= make_ecode(1'b0, req_q.wr, req_q.user);
                            faddr_q <= req_q.laddr;
                            paddr_q <= '0;
                            state_q <= WS_RESP;
                        end else begin
                            state_q <= WS_RD_TBL;
                        end
                    end
                end
                WS_RD_TBL: begin
                    if (mem_ack) begin
                        tent_q <= mem_rdata;
                        if (!mem_rdata[BIT_PRES] || viol) begin
                            fault_q <= 1'b1;
                            ecode_q <= make_ecode(mem_rdata[BIT_PRES], req_q.wr, req_q.user);
                            faddr_q <= req_q.laddr;
                            paddr_q <= '0;
                            state_q <= WS_RESP;
                        end else begin
                            paddr_q <= {mem_rdata[ADDR_W-1:OFF_W], req_q.laddr[OFF_W-1:0]};
                            state_q <= dent_chg ? WS_WR_DIR : (tent_chg ? WS_WR_TBL : WS_RESP);
                        end
                    end
                end
                WS_WR_DIR: begin
                    if (mem_ack) state_q <= tent_chg ? WS_WR_TBL : WS_RESP;
                end
                WS_WR_TBL: begin
                    if (mem_ack) state_q <= WS_RESP;
                end
                WS_RESP: begin
                    if (rsp_ready) state_q <= WS_IDLE;
                end
                default: state_q <= WS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pw_walker_chk.sv
module pw_walker_chk
    import pw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              paging_en,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_laddr,
    input logic              req_write,
    input logic              req_user,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic              rsp_fault,
    input logic [2:0]        rsp_ecode,
    input logic [ADDR_W-1:0] fault_addr,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_lock,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata,
    input logic              mem_ack
);
    logic [ADDR_W-1:0] la_cap;
    logic              wr_cap, us_cap, pg_cap, busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            la_cap <= '0; wr_cap <= 1'b0; us_cap <= 1'b0; pg_cap <= 1'b0; busy <= 1'b0;
        end else if (req_valid && req_ready) begin
            la_cap <= req_laddr; wr_cap <= req_write; us_cap <= req_user;
            pg_cap <= paging_en; busy <= 1'b1;
        end else if (rsp_valid && rsp_ready) begin
            busy <= 1'b0;
        end
    end

    AST_BYPASS_IDENTITY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !pg_cap |-> !rsp_fault && rsp_paddr == la_cap); // R1
    AST_BYPASS_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        busy && !pg_cap |-> !mem_req); // R1
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == la_cap[OFF_W-1:0]); // R3
    AST_SUPER_NO_PROT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault && !us_cap |-> !rsp_ecode[0]); // R6
    AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault |-> fault_addr == la_cap); // R7
    AST_ECODE_CTX: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault |-> rsp_ecode[1] == wr_cap && rsp_ecode[2] == us_cap); // R7
    AST_ACC_SET: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> mem_wdata[BIT_ACC]); // R8
    AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> mem_lock); // R10
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_ecode)); // R11
    AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid || mem_req |-> !req_ready); // R11
endmodule

bind pw_walker pw_walker_chk u_chk (.*);

// File: tb/pw_walker_tb.sv
module pw_walker_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] DIR_BASE = 32'h0001_0000;

    logic        clk = 1'b0, rst = 1'b1;
    logic        paging_en = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0, rsp_ready = 1'b0;
    logic [31:0] req_laddr = '0;
    logic        req_ready, rsp_valid, rsp_fault;
    logic [31:0] rsp_paddr, fault_addr;
    logic [2:0]  rsp_ecode;
    logic        mem_req, mem_we, mem_lock;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pw_walker u_dut (
        .clk(clk), .rst(rst), .paging_en(paging_en), .dir_base(DIR_BASE),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_ecode(rsp_ecode), .fault_addr(fault_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory model holding the two entries of the current walk
    logic [31:0] m_dent, m_tent, a_dir, a_tbl, first_wr_a;
    logic [31:0] rd_a [2];
    int n_rd, n_wr, bad_wr, unlocked;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (!mem_lock) unlocked++;
                if (!mem_we) begin
                    if (n_rd < 2) rd_a[n_rd] = mem_addr;
                    n_rd++;
                    mem_rdata <= (mem_addr == a_dir) ? m_dent :
                                 (mem_addr == a_tbl) ? m_tent : 32'hDEAD_BEEF;
                end else begin
                    if (n_wr == 0) first_wr_a = mem_addr;
                    n_wr++;
                    if (mem_addr == a_dir) m_dent = mem_wdata;
                    else if (mem_addr == a_tbl) m_tent = mem_wdata;
                    else bad_wr++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [31:0] last_fault = '0;

    task automatic xlate(input logic [31:0] la, input bit wr, input bit usr, input bit pg,
                         input logic [31:0] dent, input logic [31:0] tent, input int hold);
        logic [31:0] e_pa, e_dent, e_tent, e_fa, e_first;
        logic [2:0]  e_ec;
        bit          e_flt, e_us, e_rw;
        int          e_rd, e_wr, wd;
        // expected result from the requirements
        a_dir  = {DIR_BASE[31:12], la[31:22], 2'b00};
        a_tbl  = {dent[31:12], la[21:12], 2'b00};
        e_dent = dent; e_tent = tent; e_flt = 0; e_ec = 3'b000; e_pa = la;
        e_rd = 0; e_wr = 0; e_first = 32'h0;
        if (pg) begin
            e_rd = 1;
            if (!dent[0]) begin
                e_flt = 1; e_ec = {usr, wr, 1'b0};
            end else begin
                e_rd = 2;
                e_us = dent[2] & tent[2];
                e_rw = dent[1] & tent[1];
                if (!tent[0]) begin
                    e_flt = 1; e_ec = {usr, wr, 1'b0};
                end else if (usr && (!e_us || (wr && !e_rw))) begin
                    e_flt = 1; e_ec = {usr, wr, 1'b1};
                end else begin
                    e_pa = {tent[31:12], la[11:0]};
                    e_dent = dent | 32'h20;
                    e_tent = tent | 32'h20 | (wr ? 32'h40 : 32'h0);
                    if (e_tent != tent) begin e_wr++; e_first = a_tbl; end
                    if (e_dent != dent) begin e_wr++; e_first = a_dir; end
                end
            end
        end
        if (e_flt) last_fault = la;
        e_fa = last_fault;
        m_dent = dent; m_tent = tent; n_rd = 0; n_wr = 0; bad_wr = 0; unlocked = 0;
        // drive
        @(negedge clk);
        req_laddr = la; req_write = wr; req_user = usr; paging_en = pg; req_valid = 1'b1;
        chk(req_ready === 1'b1, "R11 ready when idle", {31'b0, req_ready}, 32'h1);
        @(negedge clk);
        req_valid = 1'b0;
        paging_en = ~pg;   // later changes must not matter
        wd = 0;
        while (rsp_valid !== 1'b1 && wd < 100) begin @(negedge clk); wd++; end
        chk(rsp_valid === 1'b1, "R11 response arrives", {31'b0, rsp_valid}, 32'h1);
        chk(req_ready === 1'b0, "R11 busy while responding", {31'b0, req_ready}, 32'h0);
        for (int h = 0; h < hold; h++) @(negedge clk);
        chk(rsp_valid === 1'b1, "R11 response held", {31'b0, rsp_valid}, 32'h1);
        chk(rsp_fault === e_flt, e_flt ? "R4/R5 fault flag" : "R1/R6 no fault", {31'b0, rsp_fault}, {31'b0, e_flt});
        if (e_flt) begin
            chk(rsp_ecode === e_ec, "R7 error code", {29'b0, rsp_ecode}, {29'b0, e_ec});
        end else begin
            chk(rsp_paddr === e_pa, pg ? "R3 physical address" : "R1 bypass address", rsp_paddr, e_pa);
        end
        chk(fault_addr === e_fa, "R7 fault address", fault_addr, e_fa);
        chk(n_rd == e_rd, "R4 read count", n_rd, e_rd);
        if (e_rd >= 1) chk(rd_a[0] === a_dir, "R2 directory entry address", rd_a[0], a_dir);
        if (e_rd >= 2) chk(rd_a[1] === a_tbl, "R2 table entry address", rd_a[1], a_tbl);
        chk(n_wr == e_wr, "R9 write-back count", n_wr, e_wr);
        if (e_wr > 0) chk(first_wr_a === e_first, "R9 write order", first_wr_a, e_first);
        chk(m_dent === e_dent, "R8 directory entry after walk", m_dent, e_dent);
        chk(m_tent === e_tent, "R8 table entry after walk", m_tent, e_tent);
        chk(bad_wr == 0 && unlocked == 0, "R10 locked cycles", unlocked, 0);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(rsp_valid === 1'b0, "R11 response retired", {31'b0, rsp_valid}, 32'h0);
    endtask

    function automatic logic [31:0] rnd_ent();
        logic [31:0] v = $urandom;
        v[31] = 1'b1;                        // keep tables away from the directory page
        v[0] = ($urandom % 8) != 0;
        if (($urandom % 4) != 0) v[2:1] = 2'b11;
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req === 1'b0,
            "R11 reset state", {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);
        chk(fault_addr === 32'h0, "R7 reset fault address", fault_addr, 32'h0);
        rst = 1'b0;
        // R1 bypass
        xlate(32'hCAFE_1234, 1, 1, 0, 32'h0, 32'h0, 0);
        // R4 absent directory entry, absent table entry
        xlate(32'h1234_5678, 1, 1, 1, 32'h8000_1006, 32'h0, 1);
        xlate(32'h4567_89AB, 0, 0, 1, 32'h8000_2007, 32'h9000_0066, 2);
        // R5 user read of system page (table U/S clear), user write to read-only
        xlate(32'h0040_1111, 0, 1, 1, 32'h8000_3007, 32'h9000_1003, 0);
        xlate(32'h0080_2222, 1, 1, 1, 32'h8000_4005, 32'h9000_2007, 0);
        // R6 supervisor write to read-only system page succeeds
        xlate(32'h00C0_3333, 1, 0, 1, 32'h8000_5001, 32'h9000_3001, 0);
        // R9 nothing changes: both accessed, table dirty already
        xlate(32'h0100_4444, 1, 1, 1, 32'h8000_6027, 32'h9000_4067, 0);
        // R9 only table needs dirty bit
        xlate(32'h0140_5555, 1, 1, 1, 32'h8000_7027, 32'h9000_5027, 0);
        // R8 read marks only accessed
        xlate(32'h0180_6666, 0, 1, 1, 32'h8000_8007, 32'h9000_6007, 0);
        for (int i = 0; i < 400; i++) begin
            xlate($urandom, 1'($urandom), 1'($urandom), ($urandom % 8) != 0,
                  rnd_ent(), rnd_ent(), $urandom % 3);
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule